// File: doc/BRIEF.md
# Message Request Packet Transmitter

This block sits on the transmit side of a transaction layer and turns one core-side message request into a complete posted message packet that carries one data doubleword. The core presents the requester bus, device and function numbers, an eight-bit message code, a three-bit routing code, a 64-bit address (used only for address-routed messages), one 32-bit data word, a poisoned flag and a digest-enable flag. The block captures these fields in one cycle and drives the packet out as a byte stream to the link layer under a valid/ready handshake. The stream is a four-doubleword header, then the payload doubleword, then, when enabled, a four-byte end-to-end CRC digest. A last flag marks the final byte.

Descriptor fields that messages must not use (traffic class, both attributes, tag, reserved bits) are always sent as zero. Header bytes 8 to 15 carry the address only for address-routed messages. For the slot power limit message code, every payload bit above bit 9 is cleared. The digest is produced by an internal CRC accumulator that observes the header and payload bytes as they are handed over.

A sequencer with four states controls the stream. IDLE holds the request port ready. The transition IDLE→HDR happens on an accepted request. HDR→PAY follows the handover of header byte 15. PAY→DGST follows the handover of payload byte 19 when the digest is enabled. PAY→IDLE takes its place when the digest is disabled. DGST→IDLE follows the handover of byte 23. Every other state holds while ready is low.

Top module: `msg_tlp_tx`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only when `req_ready` is 1, and `req_ready` is 1 only while no packet is being sent. Changes on the request inputs during a packet have no effect on any byte of that packet.
- R3: Byte 0 is {0, 2'b11, 2'b10, routing code[2:0]}, so bits 7:3 are 01110. The 10-bit length is 1: byte 2 bits 1:0 are 00 and byte 3 is 0x01.
- R4: Byte 1 (traffic class in bits 6:4) and byte 6 (tag) are 0x00. Byte 2 is {digest flag, poisoned flag, 6'b000000}, so the attribute and reserved bits are 0.
- R5: Byte 4 is the bus number. Byte 5 is {device[4:0], function[2:0]}. Byte 7 is the message code.
- R6: When the routing code is 3'b001, bytes 8 to 15 carry address bits 63:0 most significant byte first, with bits 1:0 of byte 15 sent as 0. For any other routing code, bytes 8 to 15 are 0x00.
- R7: Bytes 16 to 19 carry the data word most significant byte first. When the message code is 0x50, data bits 31:10 are sent as 0.
- R8: A packet is 20 bytes when the digest flag is 0 and 24 bytes when it is 1. `out_last` is 1 only on its final byte.
- R9: When the digest flag is 1, bytes 20 to 23 are a CRC-32 over bytes 0 to 19 in send order. Each byte is fed least significant bit first, with generator 04C11DB7h and preset all ones, and with byte 0 bit 0 and byte 2 bit 6 fed as 1 whatever their value. The register is kept in bit-reversed form, and its complement is sent low byte first.
- R10: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and leaves `out_byte` and `out_last` unchanged.
- R11: The cycle after the final byte is handed over, `out_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered by the core |
| req_ready | output | 1 | Block is idle and takes a request |
| req_bus | input | 8 | Requester bus number |
| req_dev | input | 5 | Requester device number |
| req_fn | input | 3 | Requester function number |
| req_code | input | 8 | Message code |
| req_route | input | 3 | Routing code |
| req_poison | input | 1 | Payload is poisoned |
| req_digest | input | 1 | Append an end-to-end CRC digest |
| req_addr | input | 64 | Address for address-routed messages |
| req_data | input | 32 | Payload doubleword |
| out_valid | output | 1 | Byte on `out_byte` is valid |
| out_ready | input | 1 | Link layer takes the byte |
| out_byte | output | 8 | Packet byte, byte 0 first |
| out_last | output | 1 | Final byte of the packet |

## Verification
Two things can happen in the same cycle: the handover of the final byte, which returns the sequencer to IDLE, and a new request that the core holds on the request port. The bench keeps `req_valid` high and scrambles every request field on each cycle of a packet. It drops `req_valid` only in the cycle where it sees the final byte offered. Correct behaviour is judged three ways. No byte of the running packet differs from the value computed from the captured request. `req_ready` stays low while bytes flow. The cycle after the final handover shows an idle port with no stray packet started.

// File: rtl/msgtx_pkg.sv
package msgtx_pkg;

    localparam int BYTE_W       = 8;
    localparam int BYTES_PER_DW = 4;
    localparam int HDR_DW       = 4;
    localparam int PAY_DW       = 1;
    localparam int DGST_DW      = 1;
    localparam int ADDR_W       = 64;
    localparam int DATA_W       = 32;
    localparam int CRC_W        = 32;
    localparam int LEN_W        = 10;
    localparam int SLOT_PWR_W   = 10;

    localparam int HDR_BYTES  = HDR_DW * BYTES_PER_DW;
    localparam int ADDR_OFS   = 8;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;
    localparam int PAY_END    = HDR_BYTES + PAY_DW * BYTES_PER_DW;
    localparam int TOT_MAX    = PAY_END + DGST_DW * BYTES_PER_DW;
    localparam int IDX_W      = $clog2(TOT_MAX);

    localparam logic [1:0]       FMT_WITH_DATA = 2'b11;
    localparam logic [1:0]       TYPE_MSG      = 2'b10;
    localparam logic [2:0]       ROUTE_BY_ADDR = 3'b001;
    localparam logic [7:0]       CODE_SLOT_PWR = 8'h50;
    localparam logic [LEN_W-1:0] LEN_ONE_DW    = LEN_W'(PAY_DW);
    localparam logic [CRC_W-1:0] CRC_POLY_REV  = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_DGST
    } seq_state_t;

    typedef struct packed {
        logic [7:0]        bus;
        logic [4:0]        dev;
        logic [2:0]        fn;
        logic [7:0]        code;
        logic [2:0]        route;
        logic              poison;
        logic              digest;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msg_req_t;

endpackage

// File: rtl/msgtx_hdr_former.sv
module msgtx_hdr_former
    import msgtx_pkg::*;
(
    input  msg_req_t          req,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] pkt_byte,
    output logic [BYTE_W-1:0] vmask
);

    logic [BYTE_W-1:0] pkt [PAY_END];
    logic [ADDR_W-1:0] addr_m;
    logic [DATA_W-1:0] data_m;

    always_comb begin
        if (req.route == ROUTE_BY_ADDR) begin
            addr_m = {req.addr[ADDR_W-1:2], 2'b00};
        end else begin
            addr_m = '0;
        end
        if (req.code == CODE_SLOT_PWR) begin
            data_m = {{(DATA_W-SLOT_PWR_W){1'b0}}, req.data[SLOT_PWR_W-1:0]};
        end else begin
            data_m = req.data;
        end
    end

    always_comb begin
        pkt[0] = {1'b0, FMT_WITH_DATA, TYPE_MSG, req.route};
        pkt[1] = {1'b0, 3'b000, 4'b0000};
        pkt[2] = {req.digest, req.poison, 2'b00, 2'b00, LEN_ONE_DW[LEN_W-1:8]};
        pkt[3] = LEN_ONE_DW[7:0];
        pkt[4] = req.bus;
        pkt[5] = {req.dev, req.fn};
        pkt[6] = 8'h00;
        pkt[7] = req.code;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            pkt[ADDR_OFS + k] = addr_m[ADDR_W - 1 - BYTE_W * k -: BYTE_W];
        end
        for (int k = 0; k < DATA_BYTES; k++) begin
            pkt[HDR_BYTES + k] = data_m[DATA_W - 1 - BYTE_W * k -: BYTE_W];
        end
    end

    always_comb begin
        if (idx < IDX_W'(PAY_END)) begin
            pkt_byte = pkt[idx];
        end else begin
            pkt_byte = '0;
        end
        if (idx == IDX_W'(0)) begin
            vmask = 8'h01;
        end else if (idx == IDX_W'(2)) begin
            vmask = 8'h40;
        end else begin
            vmask = 8'h00;
        end
    end

endmodule

// File: rtl/msgtx_ecrc_acc.sv
module msgtx_ecrc_acc
    import msgtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] vmask,
    output logic [CRC_W-1:0]  digest
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nx;

    always_comb begin
        crc_nx = crc_q ^ {{(CRC_W-BYTE_W){1'b0}}, byte_i | vmask};
        for (int b = 0; b < BYTE_W; b++) begin
            if (crc_nx[0]) begin
                crc_nx = (crc_nx >> 1) ^ CRC_POLY_REV;
            end else begin
                crc_nx = crc_nx >> 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= CRC_PRESET;
        end else if (step) begin
            crc_q <= crc_nx;
        end
    end

    assign digest = ~crc_q;

endmodule

// File: rtl/msgtx_seq.sv
module msgtx_seq
    import msgtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             with_dgst,
    input  logic             out_ready,
    output seq_state_t       state,
    output logic [IDX_W-1:0] idx,
    output logic             out_valid,
    output logic             out_last,
    output logic             fire,
    output logic             idle
);

    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] PAY_LAST = IDX_W'(PAY_END - 1);
    localparam logic [IDX_W-1:0] DG_LAST  = IDX_W'(TOT_MAX - 1);

    seq_state_t       state_nx;
    logic [IDX_W-1:0] idx_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_HDR;
                    idx_nx   = '0;
                end
            end
            ST_HDR: begin
                if (fire) begin
                    idx_nx = idx + 1'b1;
                    if (idx == HDR_LAST) begin
                        state_nx = ST_PAY;
                    end
                end
            end
            ST_PAY: begin
                if (fire) begin
                    if (idx != PAY_LAST) begin
                        idx_nx = idx + 1'b1;
                    end else if (with_dgst) begin
                        state_nx = ST_DGST;
                        idx_nx   = idx + 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                        idx_nx   = '0;
                    end
                end
            end
            ST_DGST: begin
                if (fire) begin
                    if (idx == DG_LAST) begin
                        state_nx = ST_IDLE;
                        idx_nx   = '0;
                    end else begin
                        idx_nx = idx + 1'b1;
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                idx_nx   = '0;
            end
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        out_last  = 1'b0;
        idle      = 1'b0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_HDR:  out_valid = 1'b1;
            ST_PAY: begin
                out_valid = 1'b1;
                out_last  = (idx == PAY_LAST) && !with_dgst;
            end
            ST_DGST: begin
                out_valid = 1'b1;
                out_last  = (idx == DG_LAST);
            end
            default: idle = 1'b0;
        endcase
        fire = out_valid && out_ready;
    end

endmodule

// File: rtl/msg_tlp_tx.sv
module msg_tlp_tx
    import msgtx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_fn,
    input  logic [7:0]  req_code,
    input  logic [2:0]  req_route,
    input  logic        req_poison,
    input  logic        req_digest,
    input  logic [63:0] req_addr,
    input  logic [31:0] req_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_byte,
    output logic        out_last
);

    msg_req_t          req_in;
    msg_req_t          req_q;
    seq_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  dsel;
    logic              fire;
    logic              idle;
    logic              start;
    logic [BYTE_W-1:0] pkt_byte;
    logic [BYTE_W-1:0] vmask;
    logic [CRC_W-1:0]  digest;

    always_comb begin
        req_in.bus    = req_bus;
        req_in.dev    = req_dev;
        req_in.fn     = req_fn;
        req_in.code   = req_code;
        req_in.route  = req_route;
        req_in.poison = req_poison;
        req_in.digest = req_digest;
        req_in.addr   = req_addr;
        req_in.data   = req_data;
    end

    assign req_ready = idle;
    assign start     = req_valid && idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (start) begin
            req_q <= req_in;
        end
    end

    msgtx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .with_dgst (req_q.digest),
        .out_ready (out_ready),
        .state     (state),
        .idx       (idx),
        .out_valid (out_valid),
        .out_last  (out_last),
        .fire      (fire),
        .idle      (idle)
    );

    msgtx_hdr_former u_form (
        .req      (req_q),
        .idx      (idx),
        .pkt_byte (pkt_byte),
        .vmask    (vmask)
    );

    msgtx_ecrc_acc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .step   (fire && (state != ST_DGST)),
        .byte_i (pkt_byte),
        .vmask  (vmask),
        .digest (digest)
    );

    assign dsel = idx - IDX_W'(PAY_END);

    always_comb begin
        if (state == ST_DGST) begin
            out_byte = digest[BYTE_W * dsel[1:0] +: BYTE_W];
        end else begin
            out_byte = pkt_byte;
        end
    end

endmodule

// File: rtl/msgtx_check.sv
module msgtx_check (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       out_last
);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !out_valid);

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_first_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid && (out_byte[7:3] == 5'b01110));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

    p_end_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> req_ready && !out_valid);

endmodule

bind msg_tlp_tx msgtx_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last)
);

// File: tb/msg_tlp_tx_test.sv
`timescale 1ns/1ps
module msg_tlp_tx_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [7:0]  req_bus;
    logic [4:0]  req_dev;
    logic [2:0]  req_fn;
    logic [7:0]  req_code;
    logic [2:0]  req_route;
    logic        req_poison;
    logic        req_digest;
    logic [63:0] req_addr;
    logic [31:0] req_data;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_byte;
    logic        out_last;

    always #10 clk = ~clk;

    msg_tlp_tx uut (.*);

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [7:0]  r_bus, r_code, r_dev8;
    logic [4:0]  r_dev;
    logic [2:0]  r_fn, r_route;
    logic        r_poi, r_dig;
    logic [63:0] r_addr;
    logic [31:0] r_data;

    logic [7:0] exp_b [24];
    int         exp_n;
    logic [7:0] got_b [32];
    int         got_n;

    function automatic logic [31:0] crc_of(int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = exp_b[i];
            if (i == 0) b = b | 8'h01;
            if (i == 2) b = b | 8'h40;
            c = c ^ {24'd0, b};
            for (int j = 0; j < 8; j++) begin
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
        end
        return c;
    endfunction

    task automatic build_exp();
        logic [31:0] dm = (r_code == 8'h50) ? {22'd0, r_data[9:0]} : r_data;
        logic [63:0] am = (r_route == 3'b001) ? {r_addr[63:2], 2'b00} : 64'd0;
        logic [31:0] dg;
        exp_b[0] = {1'b0, 2'b11, 2'b10, r_route};
        exp_b[1] = 8'h00;
        exp_b[2] = {r_dig, r_poi, 6'b000000};
        exp_b[3] = 8'h01;
        exp_b[4] = r_bus;
        exp_b[5] = {r_dev, r_fn};
        exp_b[6] = 8'h00;
        exp_b[7] = r_code;
        for (int k = 0; k < 8; k++) exp_b[8 + k] = am[63 - 8 * k -: 8];
        for (int k = 0; k < 4; k++) exp_b[16 + k] = dm[31 - 8 * k -: 8];
        exp_n = 20;
        if (r_dig) begin
            dg = ~crc_of(20);
            for (int k = 0; k < 4; k++) exp_b[20 + k] = dg[8 * k +: 8];
            exp_n = 24;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_bytes(input int lo, input int hi, input string req);
        bit ok = 1;
        int a = 0, e = 0;
        for (int i = lo; i <= hi; i++) begin
            if (ok && (i >= got_n || got_b[i] !== exp_b[i])) begin
                ok = 0;
                a = (i < got_n) ? int'(got_b[i]) : -1;
                e = int'(exp_b[i]);
            end
        end
        chk(ok, req, a, e);
    endtask

    task automatic scramble();
        req_bus    = 8'($urandom);
        req_dev    = 5'($urandom);
        req_fn     = 3'($urandom);
        req_code   = 8'($urandom);
        req_route  = 3'($urandom);
        req_poison = 1'($urandom);
        req_digest = 1'($urandom);
        req_addr   = {$urandom, $urandom};
        req_data   = $urandom;
    endtask

    task automatic run_pkt();
        int  cycles = 0;
        int  busy_bad = 0;
        int  hold_bad = 0;
        bit  done = 0;
        bit  prev_hold = 0;
        bit  rdy;
        logic [7:0] prev_byte;
        logic       prev_last;
        @(negedge clk);
        req_bus = r_bus; req_dev = r_dev; req_fn = r_fn; req_code = r_code;
        req_route = r_route; req_poison = r_poi; req_digest = r_dig;
        req_addr = r_addr; req_data = r_data;
        req_valid = 1'b1;
        build_exp();
        got_n = 0;
        while (!done) begin
            @(negedge clk);
            cycles++;
            if (cycles > 400) begin
                chk(0, "R8 packet timeout", got_n, exp_n);
                req_valid = 1'b0;
                break;
            end
            if (prev_hold && !(out_valid && out_byte === prev_byte && out_last === prev_last))
                hold_bad++;
            if (out_valid && req_ready) busy_bad++;
            if (out_valid) scramble();
            rdy = ($urandom % 10) < 7;
            out_ready = rdy;
            if (out_valid && rdy) begin
                if (got_n < 32) got_b[got_n] = out_byte;
                got_n++;
                if (out_last) begin
                    done = 1;
                    req_valid = 1'b0;
                end
            end
            prev_hold = out_valid && !rdy;
            prev_byte = out_byte;
            prev_last = out_last;
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(req_ready === 1'b1 && out_valid === 1'b0, "R11 idle after last", {req_ready, out_valid}, 2);
        chk(busy_bad == 0, "R2 ready low while sending", busy_bad, 0);
        chk(hold_bad == 0, "R10 hold under stall", hold_bad, 0);
        chk(got_n == exp_n, "R8 packet length and last", got_n, exp_n);
        chk_bytes(0, 0, "R3 fmt/type byte");
        chk_bytes(3, 3, "R3 length byte");
        chk_bytes(1, 2, "R4 zero descriptor, flags");
        chk_bytes(6, 6, "R4 tag zero");
        chk_bytes(4, 5, "R5 requester id");
        chk_bytes(7, 7, "R5 message code");
        chk_bytes(8, 15, "R6 address bytes");
        chk_bytes(16, 19, "R7 payload");
        if (r_dig) chk_bytes(20, 23, "R9 digest");
    endtask

    task automatic set_req(input logic [7:0] code, input logic [2:0] route,
                           input logic poi, input logic dig,
                           input logic [63:0] addr, input logic [31:0] data);
        r_dev8 = 8'($urandom);
        r_bus = 8'($urandom); r_dev = r_dev8[4:0]; r_fn = 3'($urandom);
        r_code = code; r_route = route; r_poi = poi; r_dig = dig;
        r_addr = addr; r_data = data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        req_valid = 1'b0;
        out_ready = 1'b0;
        scramble();
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 no output in reset", out_valid, 0);
        chk(req_ready === 1'b1, "R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && req_ready === 1'b1, "R1 after reset", {out_valid, req_ready}, 1);

        // slot power: local route, upper payload bits cleared, digest on (R7, R9)
        set_req(8'h50, 3'b100, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
        run_pkt();
        // address routed, low address bits set (R6)
        set_req(8'h20, 3'b001, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 32'hDEAD_BEEF);
        run_pkt();
        // poisoned with digest (R4, R9)
        set_req(8'h7E, 3'b010, 1'b1, 1'b1, 64'hAAAA_5555_AAAA_5555, 32'h1234_5678);
        run_pkt();
        // non-address route must zero bytes 8..15 (R6)
        set_req(8'h7F, 3'b011, 1'b1, 1'b0, 64'hFFFF_0000_FFFF_0003, 32'h0000_03FF);
        run_pkt();

        for (int n = 0; n < 40; n++) begin
            set_req((($urandom % 4) == 0) ? 8'h50 : 8'($urandom), 3'($urandom),
                    1'($urandom), 1'($urandom), {$urandom, $urandom}, $urandom);
            run_pkt();
        end

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule